// File: doc/BRIEF.md
# Multi-Channel SPI Master with Per-Line Chip-Select Polarity

This block is a register-programmed SPI master that serves four peripherals on one shared serial bus. Each peripheral gets its own select line and its own configuration word. That word sets the select polarity, the word length, the serial clock divisor and a hold-asserted control. A global control word turns master operation on or off and names the channel that the next word goes to. A write to the transmit address then shifts one word out, MSB first, in SPI mode 0. The bits received on the input line are collected and can be read back.

The select lines drive pads through separate value and enable outputs. Out of reset the block is a passive slave: every enable is off, so board pull-ups set the level on each line. Every polarity bit resets to 0, which means active-high. Once master mode is switched on, every line is driven to the idle level its own polarity bit implies. A channel that software never programmed therefore drives its line low, which asserts an active-low device on that line. Software must program each channel's polarity before it enables master mode.

Top module: `spi_multi_cs_master`

## Requirements
- R1: After reset, the control word, all four configuration words and the status word read 0, and every select enable (`cs_oe`) is 0.
- R2: Register addresses are as follows. Address 0 is control: bit 0 selects master mode and bits [2:1] give the target channel. Address 1 is transmit. Address 2 is receive. Address 3 is status. Addresses 4 to 7 hold the configuration words of channels 0 to 3. A write takes effect at the next clock edge. Reading a control or configuration word returns its defined fields as last written.
- R3: The configuration word has these fields: bit 1 is polarity (1 = line low while asserted, 0 = line high while asserted), bits [5:2] are the clock divisor, bits [11:7] are the word length minus one, and bit 12 is the hold-asserted control.
- R4: In slave mode every `cs_oe` bit is 0. In master mode every `cs_oe` bit is 1, and each line that is not asserted sits at its inactive level: high when its polarity bit is 1, low when it is 0.
- R5: During a transfer with no hold bit set, only the target channel's line is at its asserted level.
- R6: A transmit write made in master mode while the block is idle starts one word on the target channel. The serial clock idles low, the data output changes only on falling edges, and the input is sampled on rising edges. A transmit write made in slave mode, or while a word is in progress, has no effect.
- R7: Each serial clock phase lasts 2^k clock cycles, where k is the divisor field and any value above 12 counts as 12.
- R8: A word is (length field + 1) bits long and is sent MSB first. Length values below 3 are treated as 3, so the shortest word is 4 bits.
- R9: The status word has busy at bit 0 and one done flag per channel at bits [7:4]. A channel's done flag is set after the last bit of its word and cleared when a new word starts on that channel. The receive word holds the bits sampled during the last word, right-aligned.
- R10: When a channel's hold bit is set in master mode, its line stays at its asserted level whether or not a word is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low module reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 4 | Select line values, one per channel |
| cs_oe | output | 4 | Select line output enables |

## Verification
The assertions assume the following about the bus. A strobe is one clean cycle with address and data held steady across the edge. The input line is not expected to be valid while the block is in slave mode. The select-exclusivity property also assumes that no hold bit is set while it is being checked. The stimulus follows these assumptions: writes change only on falling edges, the data input is looped back from the data output, and every hold-bit case clears the bit before the next exclusivity check.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
    localparam int BUS_W    = 32;
    localparam int POL_BIT  = 1;
    localparam int CLKD_LSB = 2;
    localparam int CLKD_W   = 4;
    localparam int WL_LSB   = 7;
    localparam int WL_W     = 5;
    localparam int HOLD_BIT = 12;
    localparam int CLKD_MAX = 12;
    localparam int WL_MIN   = 3;
    localparam int A_CTRL   = 0;
    localparam int A_TX     = 1;
    localparam int A_RX     = 2;
    localparam int A_STAT   = 3;

    typedef struct packed {
        logic              hold;
        logic [WL_W-1:0]   wl;
        logic [CLKD_W-1:0] clkd;
        logic              pol;
    } chan_cfg_t;

    function automatic chan_cfg_t cfg_from_word(input logic [BUS_W-1:0] w);
        chan_cfg_t c;
        c.pol  = w[POL_BIT];
        c.clkd = w[CLKD_LSB +: CLKD_W];
        c.wl   = w[WL_LSB +: WL_W];
        c.hold = w[HOLD_BIT];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] cfg_to_word(input chan_cfg_t c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[POL_BIT]              = c.pol;
        w[CLKD_LSB +: CLKD_W]   = c.clkd;
        w[WL_LSB +: WL_W]       = c.wl;
        w[HOLD_BIT]             = c.hold;
        return w;
    endfunction
endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int DW   = 32,
    parameter int WLW  = 5,
    parameter int KW   = 4,
    parameter int KMAX = 12,
    parameter int WMIN = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [DW-1:0]  tx_word,
    input  logic [WLW-1:0] wl_i,
    input  logic [KW-1:0]  clkd_i,
    input  logic           miso_i,
    output logic           busy_o,
    output logic           sclk_o,
    output logic           mosi_o,
    output logic [DW-1:0]  rx_o,
    output logic           fin_o
);
    localparam int CW = (KMAX > 0) ? KMAX : 1;

    typedef struct packed {
        logic           busy;
        logic           sclk;
        logic [CW-1:0]  cnt;
        logic [CW-1:0]  lim;
        logic [WLW-1:0] bitn;
        logic [WLW-1:0] wl;
        logic [DW-1:0]  sh;
        logic [DW-1:0]  rx;
    } eng_t;

    eng_t q, d;
    logic fin;
    logic [KW-1:0]  k_eff;
    logic [WLW-1:0] wl_eff;

    always_comb begin
        d      = q;
        fin    = 1'b0;
        k_eff  = (clkd_i > KW'(KMAX)) ? KW'(KMAX) : clkd_i;
        wl_eff = (wl_i < WLW'(WMIN)) ? WLW'(WMIN) : wl_i;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.sclk = 1'b0;
                d.cnt  = '0;
                d.lim  = CW'((32'd1 << k_eff) - 32'd1);
                d.wl   = wl_eff;
                d.bitn = wl_eff;
                d.sh   = tx_word;
                d.rx   = '0;
            end
        end else if (q.cnt == q.lim) begin
            d.cnt = '0;
            if (!q.sclk) begin
                d.sclk = 1'b1;
                d.rx   = {q.rx[DW-2:0], miso_i};
            end else begin
                d.sclk = 1'b0;
                if (q.bitn == '0) begin
                    d.busy = 1'b0;
                    fin    = 1'b1;
                end else begin
                    d.bitn = q.bitn - 1'b1;
                end
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = q.busy;
    assign sclk_o = q.sclk;
    assign mosi_o = q.busy ? q.sh[q.bitn] : 1'b0;
    assign rx_o   = q.rx;
    assign fin_o  = fin;

    assert_bit_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.bitn <= q.wl));
    assert_phase_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.cnt <= q.lim));
    assert_sclk_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> !q.sclk);
endmodule

// File: rtl/spi_cs_pads.sv
module spi_cs_pads #(
    parameter int NCH = 4,
    parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           master_i,
    input  logic [NCH-1:0] pol_i,
    input  logic [NCH-1:0] hold_i,
    input  logic           xfer_i,
    input  logic [CHW-1:0] ch_i,
    output logic [NCH-1:0] cs_o,
    output logic [NCH-1:0] cs_oe
);
    for (genvar i = 0; i < NCH; i++) begin : g_line
        logic asserted;
        assign asserted = master_i && ((xfer_i && (ch_i == CHW'(i))) || hold_i[i]);
        assign cs_o[i]  = asserted ^ pol_i[i];
        assign cs_oe[i] = master_i;
    end
endmodule

// File: rtl/spi_multi_cs_master.sv
module spi_multi_cs_master #(
    parameter int NCH = 4,
    parameter int AW  = $clog2(NCH) + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic [AW-1:0]                 bus_addr,
    input  logic [spi_cs_pkg::BUS_W-1:0]  bus_wdata,
    output logic [spi_cs_pkg::BUS_W-1:0]  bus_rdata,
    output logic                          sclk_o,
    output logic                          mosi_o,
    input  logic                          miso_i,
    output logic [NCH-1:0]                cs_o,
    output logic [NCH-1:0]                cs_oe
);
    import spi_cs_pkg::*;
    localparam int CHW = $clog2(NCH);
    localparam logic [AW-1:0] ADR_CTRL = AW'(A_CTRL);
    localparam logic [AW-1:0] ADR_TX   = AW'(A_TX);
    localparam logic [AW-1:0] ADR_RX   = AW'(A_RX);
    localparam logic [AW-1:0] ADR_STAT = AW'(A_STAT);

    typedef struct packed {
        logic                      master;
        logic [CHW-1:0]            tgt;
        logic [CHW-1:0]            run;
        logic [NCH-1:0]            done;
        chan_cfg_t [NCH-1:0]       cfg;
    } regs_t;

    regs_t q, d;
    logic start, busy, fin;
    logic [BUS_W-1:0] rx_word;
    logic [NCH-1:0] polv, holdv;

    always_comb begin
        d     = q;
        start = bus_wr && (bus_addr == ADR_TX) && q.master && !busy;
        if (bus_wr) begin
            if (bus_addr == ADR_CTRL) begin
                d.master = bus_wdata[0];
                d.tgt    = bus_wdata[CHW:1];
            end else if (bus_addr[AW-1]) begin
                d.cfg[bus_addr[CHW-1:0]] = cfg_from_word(bus_wdata);
            end
        end
        if (start) begin
            d.run          = q.tgt;
            d.done[q.tgt]  = 1'b0;
        end
        if (fin) d.done[q.run] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_CTRL) begin
            bus_rdata[0]     = q.master;
            bus_rdata[CHW:1] = q.tgt;
        end else if (bus_addr == ADR_RX) begin
            bus_rdata = rx_word;
        end else if (bus_addr == ADR_STAT) begin
            bus_rdata[0]       = busy;
            bus_rdata[4 +: NCH] = q.done;
        end else if (bus_addr[AW-1]) begin
            bus_rdata = cfg_to_word(q.cfg[bus_addr[CHW-1:0]]);
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_cfgbits
        assign polv[i]  = q.cfg[i].pol;
        assign holdv[i] = q.cfg[i].hold;
    end

    spi_shift_engine #(
        .DW(BUS_W), .WLW(WL_W), .KW(CLKD_W), .KMAX(CLKD_MAX), .WMIN(WL_MIN)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(bus_wdata),
        .wl_i(q.cfg[q.tgt].wl), .clkd_i(q.cfg[q.tgt].clkd), .miso_i(miso_i),
        .busy_o(busy), .sclk_o(sclk_o), .mosi_o(mosi_o), .rx_o(rx_word), .fin_o(fin)
    );

    spi_cs_pads #(.NCH(NCH), .CHW(CHW)) u_pads (
        .master_i(q.master), .pol_i(polv), .hold_i(holdv),
        .xfer_i(busy), .ch_i(q.run), .cs_o(cs_o), .cs_oe(cs_oe)
    );

    assert_slave_undriven_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !q.master |-> (cs_oe == '0));
    assert_single_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.master && (holdv == '0)) |-> ($countones(cs_o ^ polv) == 1));
    assert_slave_tx_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADR_TX) && !q.master && !busy) |=> !busy);
endmodule

// File: tb/sim_spi_multi_cs_master.sv
`timescale 1ns/1ps
module sim_spi_multi_cs_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        sclk_o, mosi_o, miso_i;
    logic [3:0]  cs_o, cs_oe;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;
    assign miso_i = mosi_o;

    spi_multi_cs_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_o(sclk_o),
        .mosi_o(mosi_o), .miso_i(miso_i), .cs_o(cs_o), .cs_oe(cs_oe)
    );

    // serial monitor, sampled on falling clock edges
    logic        mon_clr = 1'b0;
    logic        prev_sclk = 1'b0;
    logic [31:0] cap = 32'd0;
    int          rises = 0;
    int          hi_cyc = 0;
    logic [3:0]  cs_seen = 4'd0;
    always @(negedge clk) begin
        if (mon_clr) begin
            cap = 32'd0; rises = 0; hi_cyc = 0; cs_seen = 4'd0;
        end else begin
            if (sclk_o) hi_cyc = hi_cyc + 1;
            if (sclk_o && !prev_sclk) begin
                cap = {cap[30:0], mosi_o};
                rises = rises + 1;
                cs_seen = cs_o;
            end
        end
        prev_sclk = sclk_o;
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    function automatic logic [31:0] cfgw(input int pol, input int clkd, input int wl, input int hold);
        return 32'((hold << 12) | (wl << 7) | (clkd << 2) | (pol << 1));
    endfunction

    task automatic wait_idle();
        logic [31:0] s;
        for (int n = 0; n < 60000; n++) begin
            rd(3'd3, s);
            if (!s[0]) return;
        end
        chk("R9 busy never cleared", 32'd1, 32'd0);
    endtask

    task automatic send(input logic [31:0] v);
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
        wr(3'd1, v);
        wait_idle();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); chk("R1 ctrl", v, 0);
        for (int c = 0; c < 4; c++) begin
            rd(3'(4 + c), v); chk("R1 cfg", v, 0);
        end
        rd(3'd3, v); chk("R1 status", v, 0);
        chk("R1 cs_oe", 32'(cs_oe), 0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(3'd6, cfgw(1, 9, 21, 1));
        rd(3'd6, v); chk("R2 R3 cfg readback", v, cfgw(1, 9, 21, 1));
        wr(3'd0, 32'h5);
        rd(3'd0, v); chk("R2 ctrl readback", v, 32'h5);
        wr(3'd0, 32'h0);
        wr(3'd6, 32'h0);
    endtask

    task automatic t_master_levels();
        wr(3'd0, 32'h1);
        @(negedge clk);
        chk("R4 oe on in master", 32'(cs_oe), 32'hF);
        chk("R4 unprogrammed idle low", 32'(cs_o), 32'h0);
        wr(3'd4, cfgw(1, 0, 7, 0));
        wr(3'd5, cfgw(1, 0, 7, 0));
        @(negedge clk);
        chk("R4 mixed idle levels", 32'(cs_o), 32'h3);
        wr(3'd6, cfgw(1, 0, 7, 0));
        wr(3'd7, cfgw(1, 0, 7, 0));
        @(negedge clk);
        chk("R4 all idle high", 32'(cs_o), 32'hF);
    endtask

    task automatic t_slave_ignored();
        logic [31:0] v;
        wr(3'd0, 32'h0);
        @(negedge clk);
        chk("R4 oe off in slave", 32'(cs_oe), 32'h0);
        wr(3'd1, 32'hAA);
        repeat (4) @(negedge clk);
        rd(3'd3, v); chk("R6 slave tx ignored", v, 32'h0);
    endtask

    task automatic t_basic_xfer();
        logic [31:0] v;
        wr(3'd5, cfgw(1, 0, 7, 0));
        wr(3'd0, 32'h3);
        send(32'hA5);
        chk("R8 MSB first data", cap, 32'hA5);
        chk("R8 bit count", 32'(rises), 8);
        chk("R5 only ch1 asserted", 32'(cs_seen), 32'hD);
        chk("R7 divisor 0 phase", 32'(hi_cyc), 8);
        rd(3'd2, v); chk("R9 rx word", v, 32'hA5);
        rd(3'd3, v); chk("R9 done ch1", v, 32'h20);
        chk("R6 select released", 32'(cs_o), 32'hF);
    endtask

    task automatic t_divisor();
        wr(3'd7, cfgw(1, 2, 3, 0));
        wr(3'd0, 32'h7);
        send(32'h9);
        chk("R7 divisor 2 phase", 32'(hi_cyc), 16);
        chk("R5 only ch3 asserted", 32'(cs_seen), 32'h7);
        chk("R8 4-bit data", cap, 32'h9);
        wr(3'd7, cfgw(1, 15, 3, 0));
        send(32'h6);
        chk("R7 divisor clamp", 32'(hi_cyc), 4 * 4096);
    endtask

    task automatic t_word_length();
        logic [31:0] v;
        wr(3'd7, cfgw(1, 0, 0, 0));
        send(32'hF6);
        chk("R8 minimum length bits", 32'(rises), 4);
        chk("R8 minimum length data", cap, 32'h6);
        wr(3'd7, cfgw(1, 0, 31, 0));
        send(32'hDEADBEEF);
        chk("R8 full length bits", 32'(rises), 32);
        chk("R8 full length data", cap, 32'hDEADBEEF);
        rd(3'd2, v); chk("R9 rx full word", v, 32'hDEADBEEF);
    endtask

    task automatic t_busy_ignored();
        logic [31:0] v;
        wr(3'd5, cfgw(1, 1, 7, 0));
        wr(3'd0, 32'h3);
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
        wr(3'd1, 32'h3C);
        rd(3'd3, v); chk("R9 done cleared on start", v, 32'h81);
        wr(3'd1, 32'hFF);
        wait_idle();
        chk("R6 busy tx ignored data", cap, 32'h3C);
        chk("R6 busy tx ignored count", 32'(rises), 8);
        rd(3'd3, v); chk("R9 done flags", v, 32'hA0);
    endtask

    task automatic t_hold();
        wr(3'd6, cfgw(1, 0, 7, 1));
        @(negedge clk);
        chk("R10 hold asserts idle", 32'(cs_o), 32'hB);
        send(32'h11);
        chk("R10 hold during other xfer", 32'(cs_seen), 32'h9);
        chk("R10 hold after xfer", 32'(cs_o), 32'hB);
        wr(3'd6, cfgw(1, 0, 7, 0));
        @(negedge clk);
        chk("R10 hold released", 32'(cs_o), 32'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_master_levels();
        t_slave_ignored();
        t_basic_xfer();
        t_divisor();
        t_word_length();
        t_busy_ignored();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #3000000;
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule